// File: doc/BRIEF.md
# Integer ALU with Signed Overflow Detect

This block is the combinational arithmetic and logic unit of a small load/store RISC core. It takes two 32-bit operands, a 4-bit operation code and a 5-bit shift distance. It returns a 32-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag for addition and subtraction.

Subtraction adds the second operand's bitwise inverse with a carry-in of one, so a single adder serves both operations. Overflow comes only from the operand and result signs, never from the carry out of the top bit. Set-on-less-than uses the same subtraction and corrects the difference's sign by the overflow term, so it still orders operands whose difference does not fit in 32 bits.

Because the block has no state, a clock and an active-low reset are present only so that its own clocked assertions can sample the outputs.

Top module: `int_alu`

## Requirements
- R1: With op = 4'b0010, result equals (a + b) mod 2^32, and ovf is 1 exactly when a and b have the same sign bit and result has the other sign bit.
- R2: With op = 4'b1010, result equals (a - b) mod 2^32, formed as a + ~b + 1, and ovf is 1 exactly when a and b differ in sign and result's sign differs from a's sign.
- R3: A carry out of bit 31 alone never sets ovf. For example, 0xFFFFFFFF + 0x00000001 gives result 0 and ovf 0.
- R4: With op = 4'b0000, 4'b0001, 4'b0011 and 4'b1100, result is a AND b, a OR b, a XOR b and NOT(a OR b) respectively.
- R5: With op = 4'b0111, result is 1 when a < b as signed 32-bit integers and 0 otherwise, with bits 31:1 zero. This holds even when a - b overflows.
- R6: With op = 4'b0100 (shift left) and 4'b0101 (logical shift right), b is shifted by shamt, and the vacated bits are filled with zeros.
- R7: With op = 4'b0110, b is shifted right by shamt, and the vacated high bits are filled with copies of b[31].
- R8: zero is 1 exactly when all 32 result bits are 0, for every op.
- R9: ovf is 0 for every op other than 4'b0010 and 4'b1010. Any unlisted op code gives result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the assertions only |
| rst_n | input | 1 | Active-low reset that disables the assertions |
| a | input | 32 | First operand |
| b | input | 32 | Second operand; this is the value that the shift ops move |
| op | input | 4 | Operation select |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow for ADD and SUB |

## Verification
On every sampled cycle, the assertions check these properties:
- the overflow flag agrees with the sign rule for ADD and SUB, and is low for every other op;
- the zero flag matches the result;
- set-on-less-than only ever produces 0 or 1;
- the arithmetic shift replicates the sign bit into the vacated bits.

Some behaviour can only be shown by the bench's scenarios, because it needs an independently computed expected value:
- the exact sums, differences, logic results and shift values;
- set-on-less-than ordering across overflowing operand pairs;
- the carry-out-without-overflow corner.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [3:0]    op,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          zero,
  output logic          ovf
);
  localparam logic [3:0] OP_AND = 4'b0000, OP_OR  = 4'b0001, OP_ADD = 4'b0010,
                         OP_XOR = 4'b0011, OP_SLL = 4'b0100, OP_SRL = 4'b0101,
                         OP_SRA = 4'b0110, OP_SLT = 4'b0111, OP_SUB = 4'b1010,
                         OP_NOR = 4'b1100;

  logic          is_sub;
  logic [W-1:0]  b_eff;
  logic [W:0]    sum_full;
  logic [W-1:0]  sum;
  logic          arith_ovf;
  logic          less;

  assign is_sub    = (op == OP_SUB) || (op == OP_SLT);
  assign b_eff     = is_sub ? ~b : b;
  assign sum_full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign sum       = sum_full[W-1:0];
  assign arith_ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign less      = sum[W-1] ^ arith_ovf;

  always_comb begin
    unique case (op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NOR:  result = ~(a | b);
      OP_ADD,
      OP_SUB:  result = sum;
      OP_SLT:  result = {{(W-1){1'b0}}, less};
      OP_SLL:  result = b << shamt;
      OP_SRL:  result = b >> shamt;
      OP_SRA:  result = $signed(b) >>> shamt;
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
  assign ovf  = ((op == OP_ADD) || (op == OP_SUB)) && arith_ovf;

  a_r1_add_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |-> (ovf == ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1]))));
  a_r2_sub_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (ovf == ((a[W-1] != b[W-1]) && (result[W-1] != a[W-1]))));
  a_r5_slt_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLT) |-> (result[W-1:1] == '0));
  a_r7_sra_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SRA && b[W-1] && shamt != '0) |-> result[W-1]);
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero == ($countones(result) == 0));
  a_r9_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_ADD && op != OP_SUB) |-> !ovf);
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] a, b, result;
  logic [3:0]  op;
  logic [4:0]  shamt;
  logic        zero, ovf;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  int_alu dut_i (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .shamt(shamt),
                 .result(result), .zero(zero), .ovf(ovf));

  function automatic logic [31:0] exp_res(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0011: return x ^ y;
      4'b1100: return ~(x | y);
      4'b0010: return x + y;
      4'b1010: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b0100: return y << s;
      4'b0101: return y >> s;
      4'b0110: return $signed(y) >>> s;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    longint t;
    if (o == 4'b0010) t = longint'($signed(x)) + longint'($signed(y));
    else if (o == 4'b1010) t = longint'($signed(x)) - longint'($signed(y));
    else return 1'b0;
    return (t > 64'sd2147483647) || (t < -64'sd2147483648);
  endfunction

  function automatic string tag(logic [3:0] o);
    case (o)
      4'b0010: return "R1";
      4'b1010: return "R2";
      4'b0111: return "R5";
      4'b0100, 4'b0101: return "R6";
      4'b0110: return "R7";
      4'b0000, 4'b0001, 4'b0011, 4'b1100: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    logic [31:0] er;
    logic eo;
    @(negedge clk);
    op = o; a = x; b = y; shamt = s;
    #1;
    er = exp_res(o, x, y, s);
    eo = exp_ovf(o, x, y);
    nchk++;
    if (result !== er) begin
      nfail++;
      $display("FAIL %s op=%b result=%h expected=%h", tag(o), o, result, er);
    end
    if (ovf !== eo) begin
      nfail++;
      $display("FAIL %s/R9 op=%b ovf=%b expected=%b", tag(o), o, ovf, eo);
    end
    if (zero !== (er == 0)) begin
      nfail++;
      $display("FAIL R8 op=%b zero=%b expected=%b", o, zero, er == 0);
    end
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog result=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] ops [10];
    void'($urandom(32'h5eed));
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010, 4'b1100};
    op = 0; a = 0; b = 0; shamt = 0;
    #1;
    nchk++;
    if (result !== 0 || zero !== 1 || ovf !== 0) begin
      nfail++;
      $display("FAIL R8 reset-state result=%h zero=%b expected=0/1", result, zero);
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    apply(4'b0010, 32'h7FFFFFFF, 32'h1, 0);           // R1 overflow
    apply(4'b0010, 32'h80000000, 32'h80000000, 0);    // R1 neg overflow
    apply(4'b0010, 32'hFFFFFFFF, 32'h1, 0);           // R3 carry no overflow
    apply(4'b0010, 32'h7FFFFFFF, 32'hFFFFFFFF, 0);    // R1 mixed sign
    apply(4'b1010, 32'h80000000, 32'h1, 0);           // R2 overflow
    apply(4'b1010, 32'h7FFFFFFF, 32'hFFFFFFFF, 0);    // R2 overflow
    apply(4'b1010, 32'hFFFFFFF0, 32'hFFFFFFF0, 0);    // R2 same sign, zero result
    apply(4'b0111, 32'h80000000, 32'h1, 0);           // R5 overflow case
    apply(4'b0111, 32'h7FFFFFFF, 32'h80000000, 0);    // R5 overflow case
    apply(4'b0111, 32'h5, 32'h5, 0);                  // R5 equal
    apply(4'b0111, 32'hFFFFFFFF, 32'h0, 0);           // R5
    apply(4'b0110, 32'h0, 32'h80000000, 31);          // R7
    apply(4'b0110, 32'h0, 32'h80000000, 0);           // R7 zero shift
    apply(4'b0101, 32'h0, 32'h80000000, 31);          // R6
    apply(4'b0100, 32'h0, 32'h1, 31);                 // R6
    apply(4'b1100, 32'h0, 32'h0, 0);                  // R4 nor as not
    apply(4'b1111, 32'h12345678, 32'h9ABCDEF0, 3);    // R9 unlisted
    apply(4'b1000, 32'hFFFFFFFF, 32'h1, 0);           // R9 unlisted
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (i % 4 == 0) ? x : $urandom;
      if (i % 7 == 0) x[31] = ~x[31];
      apply(ops[$urandom % 10], x, y, 5'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule